// File: doc/BRIEF.md
# Serial Debug Wire Mode-Switch Sequence Generator

This block sits on the host side of a two-wire debug link and emits the fixed bit streams that move a target's debug port between its JTAG and serial-wire personalities, force a serial-wire line reset, or send the port to its low-power dormant state. A single strobe with a two-bit command code launches one stream. The block then drives the data line and toggles the clock line until the last bit has been clocked, and it signals completion with a one-cycle flag.

Every stream is assembled from up to four segments: a run of 50 high bits that resets either interface, an optional 16-bit selection code sent least-significant bit first, an optional run of high bits, and an optional run of low bits. One bit occupies one wire clock period. The wire clock half-period is programmable in system clocks. Data changes only at the falling edge of the wire clock, so the target sees it stable at the rising edge.

Top module: `swj_seq_gen`

## Requirements
- R1: After reset, and whenever no stream is in progress, `swclk` is 0, `swdio` is 0, `swdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Command 0 (line reset) emits exactly 51 bits: 50 ones followed by one zero.
- R3: Command 1 (JTAG to serial wire) emits exactly 118 bits: 50 ones, the code 0xE79E with bit 0 first, 50 ones, then two zeros.
- R4: Command 2 (serial wire to JTAG) emits exactly 71 bits: 50 ones, the code 0xE73C with bit 0 first, then five ones.
- R5: Command 3 (serial wire to dormant) emits exactly 66 bits: 50 ones followed by the code 0xE3BC with bit 0 first, with no trailer.
- R6: With effective half-period H, each bit lasts 2H system clocks: `swclk` is low for the first H and high for the last H. The first bit is presented in the cycle after the accepted strobe, and `swdio` changes only when `swclk` falls.
- R7: `half_div` is captured when a strobe is accepted and later changes have no effect on the running stream. A captured value of 0 behaves as 1.
- R8: A `start` strobe seen while `busy` is 1 is ignored: the running stream, its command and its timing continue unchanged.
- R9: `busy` is 1 from the cycle after an accepted strobe through the last bit's high phase. In the following cycle `busy` is 0, `swclk` is 0 and `done` is 1 for exactly one cycle.
- R10: `swdio_oe` is 1 exactly while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| cmd | input | 2 | Stream select: 0 line reset, 1 JTAG to serial wire, 2 serial wire to JTAG, 3 serial wire to dormant |
| half_div | input | DIV_W | Wire clock half-period in system clocks (0 treated as 1) |
| swclk | output | 1 | Wire clock, idles low |
| swdio | output | 1 | Wire data (also serves as TMS) |
| swdio_oe | output | 1 | Data output enable |
| busy | output | 1 | Stream in progress |
| done | output | 1 | One-cycle pulse after the last bit period |

## Verification
The hardest case to reach from the ports is a strobe that arrives in the middle of a stream, carrying a different command and divider that would visibly change both the bit values and the period if it were taken. The bench raises such a strobe partway through the reset run of a long stream and then checks every following cycle against the original command's timing. It also changes `half_div` right after each accepted strobe, and it sweeps every command at several half-periods, including a zero divider. These runs confirm that both the segment boundaries and the per-bit timing depend only on what was captured at acceptance.

// File: rtl/swj_seq_pkg.sv
package swj_seq_pkg;

  localparam int RESET_RUN  = 50;
  localparam int CODE_W     = 16;
  localparam int CNT_W      = 7;
  localparam int CODE_IDX_W = $clog2(CODE_W);

  typedef enum logic [1:0] {
    CMD_LINE_RESET     = 2'd0,
    CMD_JTAG_TO_SWD    = 2'd1,
    CMD_SWD_TO_JTAG    = 2'd2,
    CMD_SWD_TO_DORMANT = 2'd3
  } swj_cmd_e;

  typedef enum logic [2:0] {
    SEG_RUN     = 3'd0,
    SEG_CODE    = 3'd1,
    SEG_TAIL_HI = 3'd2,
    SEG_TAIL_LO = 3'd3,
    SEG_IDLE    = 3'd4
  } seg_e;

  typedef struct packed {
    logic              has_code;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  tail_hi;
    logic [CNT_W-1:0]  tail_lo;
  } seg_plan_t;

  // Move forward past segments that carry no bits for this plan.
  function automatic seg_e skip_empty(input seg_e s, input seg_plan_t p);
    seg_e r;
    r = s;
    if (r == SEG_CODE && !p.has_code) r = SEG_TAIL_HI;
    if (r == SEG_TAIL_HI && p.tail_hi == '0) r = SEG_TAIL_LO;
    if (r == SEG_TAIL_LO && p.tail_lo == '0) r = SEG_IDLE;
    return r;
  endfunction

endpackage

// File: rtl/swj_pattern_table.sv
module swj_pattern_table
  import swj_seq_pkg::*;
#(
  parameter logic [CODE_W-1:0] SEL_TO_SWD     = 16'hE79E,
  parameter logic [CODE_W-1:0] SEL_TO_JTAG    = 16'hE73C,
  parameter logic [CODE_W-1:0] SEL_TO_DORMANT = 16'hE3BC,
  parameter int TAP_RESET_ONES   = 5,
  parameter int LINE_IDLE_ZEROS  = 1,
  parameter int SWITCH_IDLE_ZEROS = 2
) (
  input  swj_cmd_e  cmd,
  output seg_plan_t plan
);

  localparam logic [CNT_W-1:0] RUN_LEN  = CNT_W'(RESET_RUN);
  localparam logic [CNT_W-1:0] TAP_ONES = CNT_W'(TAP_RESET_ONES);
  localparam logic [CNT_W-1:0] LINE_Z   = CNT_W'(LINE_IDLE_ZEROS);
  localparam logic [CNT_W-1:0] SW_Z     = CNT_W'(SWITCH_IDLE_ZEROS);

  always_comb begin
    plan = '0;
    unique case (cmd)
      CMD_LINE_RESET: begin
        plan.has_code = 1'b0;
        plan.tail_lo  = LINE_Z;
      end
      CMD_JTAG_TO_SWD: begin
        plan.has_code = 1'b1;
        plan.code     = SEL_TO_SWD;
        plan.tail_hi  = RUN_LEN;
        plan.tail_lo  = SW_Z;
      end
      CMD_SWD_TO_JTAG: begin
        plan.has_code = 1'b1;
        plan.code     = SEL_TO_JTAG;
        plan.tail_hi  = TAP_ONES;
      end
      CMD_SWD_TO_DORMANT: begin
        plan.has_code = 1'b1;
        plan.code     = SEL_TO_DORMANT;
      end
      default: plan = '0;
    endcase
  end

endmodule

// File: rtl/swj_clk_timer.sv
module swj_clk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             swclk,
  output logic             bit_end
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             at_toggle;

  assign at_toggle = (cnt_q == half_q - ONE);
  assign bit_end   = run && clk_q && at_toggle;
  assign swclk     = clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= ONE;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else if (load) begin
      half_q <= (div_in == '0) ? ONE : div_in;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else if (at_toggle) begin
      cnt_q  <= '0;
      clk_q  <= ~clk_q;
    end else begin
      cnt_q  <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/swj_bit_sequencer.sv
module swj_bit_sequencer
  import swj_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      advance,
  input  seg_plan_t plan,
  output logic      data,
  output logic      last_bit
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RESET_RUN - 1);
  localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);

  seg_e             seg_q, follower, nxt_seg;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             seg_end, data_q, nxt_data;

  always_comb begin
    unique case (seg_q)
      SEG_RUN:     seg_end = (cnt_q == RUN_LAST);
      SEG_CODE:    seg_end = (cnt_q == CODE_LAST);
      SEG_TAIL_HI: seg_end = (cnt_q == plan.tail_hi - ONE);
      SEG_TAIL_LO: seg_end = (cnt_q == plan.tail_lo - ONE);
      default:     seg_end = 1'b1;
    endcase

    unique case (seg_q)
      SEG_RUN:     follower = SEG_CODE;
      SEG_CODE:    follower = SEG_TAIL_HI;
      SEG_TAIL_HI: follower = SEG_TAIL_LO;
      default:     follower = SEG_IDLE;
    endcase

    nxt_seg = seg_end ? skip_empty(follower, plan) : seg_q;
    nxt_cnt = seg_end ? '0 : cnt_q + ONE;

    unique case (nxt_seg)
      SEG_RUN:     nxt_data = 1'b1;
      SEG_CODE:    nxt_data = plan.code[nxt_cnt[CODE_IDX_W-1:0]];
      SEG_TAIL_HI: nxt_data = 1'b1;
      default:     nxt_data = 1'b0;
    endcase
  end

  assign last_bit = (nxt_seg == SEG_IDLE);
  assign data     = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= SEG_IDLE;
      cnt_q  <= '0;
      data_q <= 1'b0;
    end else if (load) begin
      seg_q  <= SEG_RUN;
      cnt_q  <= '0;
      data_q <= 1'b1;
    end else if (advance) begin
      seg_q  <= nxt_seg;
      cnt_q  <= nxt_cnt;
      data_q <= nxt_data;
    end
  end

endmodule

// File: rtl/swj_seq_gen.sv
module swj_seq_gen
  import swj_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [DIV_W-1:0] half_div,
  output logic             swclk,
  output logic             swdio,
  output logic             swdio_oe,
  output logic             busy,
  output logic             done
);

  logic      busy_q, done_q, oe_q;
  logic      accept, bit_end, last_bit, finish;
  swj_cmd_e  cmd_q;
  seg_plan_t plan;

  assign accept = start && !busy_q;
  assign finish = bit_end && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_LINE_RESET;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        cmd_q  <= swj_cmd_e'(cmd);
        busy_q <= 1'b1;
        oe_q   <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
      end
    end
  end

  swj_pattern_table table_i (
    .cmd  (cmd_q),
    .plan (plan)
  );

  swj_clk_timer #(.DIV_W(DIV_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .run     (busy_q),
    .div_in  (half_div),
    .swclk   (swclk),
    .bit_end (bit_end)
  );

  swj_bit_sequencer seq_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .advance  (bit_end),
    .plan     (plan),
    .data     (swdio),
    .last_bit (last_bit)
  );

  assign busy     = busy_q;
  assign done     = done_q;
  assign swdio_oe = oe_q;

endmodule

// File: rtl/swj_seq_gen_chk.sv
module swj_seq_gen_chk (
  input logic clk,
  input logic rst,
  input logic swclk,
  input logic swdio,
  input logic swdio_oe,
  input logic busy,
  input logic done
);

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !swclk); // R1

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    swclk |-> $stable(swdio)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy && !swclk)); // R9

  AST_OE_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    swdio_oe == busy); // R10

endmodule

bind swj_seq_gen swj_seq_gen_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .swclk    (swclk),
  .swdio    (swdio),
  .swdio_oe (swdio_oe),
  .busy     (busy),
  .done     (done)
);

// File: tb/swj_seq_gen_tb.sv
`timescale 1ns/1ps
module swj_seq_gen_tb_top;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [1:0]       cmd = 2'd0;
  logic [DIV_W-1:0] half_div = '0;
  logic swclk, swdio, swdio_oe, busy, done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  swj_seq_gen #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .half_div(half_div),
    .swclk(swclk), .swdio(swdio), .swdio_oe(swdio_oe), .busy(busy), .done(done)
  );

  function automatic int exp_len(input int k);
    case (k)
      0: return 51;   // R2
      1: return 118;  // R3
      2: return 71;   // R4
      default: return 66; // R5
    endcase
  endfunction

  function automatic bit exp_bit(input int k, input int i);
    logic [15:0] code;
    if (i < 50) return 1'b1;
    case (k)
      0: return 1'b0;
      1: begin
        code = 16'hE79E;
        if (i < 66) return code[i-50];
        return (i < 116);
      end
      2: begin
        code = 16'hE73C;
        if (i < 66) return code[i-50];
        return 1'b1;
      end
      default: begin
        code = 16'hE3BC;
        return code[i-50];
      end
    endcase
  endfunction

  function automatic string dio_tag(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, swclk, 0);
    chk(tag, swdio, 0);
    chk(tag, swdio_oe, 0);
    chk(tag, busy, 0);
    chk(tag, done, 0);
  endtask

  // Launch one stream and compare every cycle against the arithmetic model.
  task automatic run_case(input int k, input int div, input int h, input bit inject,
                          input string ttag);
    int n, per, total, idx, ph, done_seen;
    n = exp_len(k);
    per = 2 * h;
    total = n * per;
    done_seen = 0;
    start = 1'b1;
    cmd = 2'(k);
    half_div = DIV_W'(div);
    @(negedge clk);
    start = 1'b0;
    half_div = DIV_W'(7); // R7: later divider changes must not matter
    for (int c = 1; c <= total + 2; c++) begin
      if (done) done_seen++;
      if (c <= total) begin
        idx = (c - 1) / per;
        ph  = (c - 1) % per;
        chk("R9 busy", busy, 1);
        chk(ttag, swclk, (ph >= h) ? 1 : 0);
        chk(dio_tag(k), swdio, exp_bit(k, idx));
        chk("R10", swdio_oe, 1);
        chk("R9 done", done, 0);
      end else if (c == total + 1) begin
        chk("R9 end busy", busy, 0);
        chk("R9 end done", done, 1);
        chk("R9 end clk", swclk, 0);
        chk("R10 end", swdio_oe, 0);
      end else begin
        chk("R9 pulse", done, 0);
        chk("R1 idle", swclk, 0);
      end
      if (inject && (c == 37 || c == 38)) begin
        start = 1'b1;        // R8: strobe while busy
        cmd = 2'((k + 2) % 4);
        half_div = DIV_W'(1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk("R8 one done", done_seen, 1);
    half_div = '0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    @(negedge clk);

    for (int k = 0; k < 4; k++) begin
      for (int h = 1; h <= 3; h++) begin
        run_case(k, h, h, 1'b0, "R6");
      end
    end

    run_case(0, 0, 1, 1'b0, "R6,R7 zero");
    run_case(3, 0, 1, 1'b0, "R6,R7 zero");
    run_case(1, 2, 2, 1'b1, "R6,R8");
    run_case(2, 3, 3, 1'b1, "R6,R8");

    check_idle("R1 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule